// File: doc/BRIEF.md
# Serial Register-Write Slave with Readback

This block is the serial port of a multi-channel converter's register bank. A host sends 24-bit frames. An active-low frame line (`sync_n`) bounds each frame. Serial data is taken on the falling edges of the serial clock. Each channel has four 16-bit registers:

- two input registers, A and B
- an offset register
- a gain register

A frame either writes one register of the addressed channel or carries a special command. One special command sets the input-register bank select. Another special command arms a readback: during the following frame, the selected register is shifted out on the serial output, which is enabled only while it carries readback data.

The three serial pins arrive asynchronously. Each passes through a two-flop synchronizer into the system clock domain, and all edges are detected from the synchronized levels. A frame takes effect only when `sync_n` returns high after exactly 24 falling clock edges. A frame with fewer edges is dropped. A frame with more edges is dropped and reported on a status output.

Top module: `spi_reg_slave`

## Requirements
- R1: The frame layout is fixed. Bits [23:22] are the mode, bits [21:16] are the address and bits [15:0] are the data. The first bit sent is bit 23, and each bit is taken on a falling edge of `sclk` while `sync_n` is low.
- R2: If `sync_n` rises after fewer than 24 falling edges of `sclk`, the frame is discarded. No register changes and no readback is armed.
- R3: The decoded frame takes effect only on the rising edge of `sync_n` that follows exactly 24 falling edges of `sclk`.
- R4: If a 25th falling edge arrives in one frame, the frame is discarded. `overrun` is high from that edge until the next falling edge of `sync_n`.
- R5: Mode 2'b11 writes the data to input register A of the addressed channel when the bank select is 0, and to input register B when it is 1. Mode 2'b10 writes the offset register and mode 2'b01 writes the gain register. Writes to an address of NUM_CH or above are ignored.
- R6: A mode 2'b00 frame with address 6'h01 loads the bank select from data bit 0. Other mode 2'b00 addresses, apart from 6'h05, change nothing.
- R7: A mode 2'b00 frame with address 6'h05 arms a readback, and `sdo_oe` goes high at its commit. Data bits [7:6] choose the register: 00 for input A, 01 for input B, 10 for offset, 11 for gain. Data bits [5:0] choose the channel. The word sent is {8'h00, value}, taken when the readback is armed. A channel of NUM_CH or above reads as zero.
- R8: In the frame after the readback is armed, `sdo` carries word bit 23 from the start of the frame. It moves one bit lower on each rising edge of `sclk` that follows a falling edge. `sdo_oe` drops after the 24th falling edge, or at the rise of `sync_n` if that comes first.
- R9: After reset, input registers A and B are 0, offset registers are 16'h8000 and gain registers are 16'hFFFF. The bank select is 0, and `sdo_oe`, `sdo` and `overrun` are low. While `sdo_oe` is low, `sdo` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_n | input | 1 | Active-low frame line (asynchronous) |
| sclk | input | 1 | Serial clock, idle high (asynchronous) |
| sdi | input | 1 | Serial data in (asynchronous) |
| sdo | output | 1 | Serial readback data, 0 when not enabled |
| sdo_oe | output | 1 | Output enable for the `sdo` pad driver |
| overrun | output | 1 | Frame had more than 24 falling clock edges |

## Verification
The assertions check several behaviours on every cycle:

- a commit appears only right after a `sync_n` rise, and never after a short or overlong frame
- `overrun` holds until the next frame starts
- the bank select moves only on a commit
- the output enable rises only on an arm and drops after the 24th bit it serves

Some behaviours only the bench scenarios can show:

- the register contents and the bit order coming out of `sdo`
- the routing of input writes by the bank select
- the ignored out-of-range channels and unknown special addresses
- the discarding of truncated and overlong frames

The bench shows these by reading registers back through later frames and comparing every bit against its model.

// File: rtl/spi_rs_pkg.sv
package spi_rs_pkg;
  localparam int FRAME_W = 24;
  localparam int ADDR_W  = 6;
  localparam int DATA_W  = 16;

  typedef enum logic [1:0] {
    MD_SPECIAL = 2'b00,
    MD_GAIN    = 2'b01,
    MD_OFFSET  = 2'b10,
    MD_INPUT   = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    RK_IN_A = 2'b00,
    RK_IN_B = 2'b01,
    RK_OFS  = 2'b10,
    RK_GAIN = 2'b11
  } rkind_e;

  typedef struct packed {
    mode_e               mode;
    logic [ADDR_W-1:0]   addr;
    logic [DATA_W-1:0]   data;
  } frame_t;

  localparam logic [ADDR_W-1:0] SF_BANKSEL = 6'h01;
  localparam logic [ADDR_W-1:0] SF_READ    = 6'h05;

  localparam logic [DATA_W-1:0] RST_IN   = 16'h0000;
  localparam logic [DATA_W-1:0] RST_OFS  = 16'h8000;
  localparam logic [DATA_W-1:0] RST_GAIN = 16'hFFFF;

  function automatic logic is_banksel(frame_t f);
    return (f.mode == MD_SPECIAL) && (f.addr == SF_BANKSEL);
  endfunction

  function automatic logic is_readcmd(frame_t f);
    return (f.mode == MD_SPECIAL) && (f.addr == SF_READ);
  endfunction

  function automatic logic [FRAME_W-1:0] pack_rb(logic [DATA_W-1:0] v);
    return {{(FRAME_W-DATA_W){1'b0}}, v};
  endfunction
endpackage

// File: rtl/spi_rs_sync.sv
module spi_rs_sync #(
  parameter int             W       = 3,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [STAGES-1:0][W-1:0] stg;
  logic [W-1:0]             prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg  <= {STAGES{RST_VAL}};
      prev <= RST_VAL;
    end else begin
      stg  <= {stg[STAGES-2:0], din};
      prev <= stg[STAGES-1];
    end
  end

  assign lvl = stg[STAGES-1];

  for (genvar b = 0; b < W; b++) begin : g_edge
    assign rise[b] = lvl[b] & ~prev[b];
    assign fall[b] = ~lvl[b] & prev[b];
  end
endmodule

// File: rtl/spi_rs_frame_rx.sv
module spi_rs_frame_rx
  import spi_rs_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sync_lvl,
  input  logic   sync_fall,
  input  logic   sync_rise,
  input  logic   sclk_fall,
  input  logic   sdi_lvl,
  output logic   commit,
  output frame_t frame_o,
  output logic   overrun
);
  localparam int                CNT_W = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0]  FULL  = CNT_W'(FRAME_W);

  logic [CNT_W-1:0]   cnt;
  logic [FRAME_W-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      shreg   <= '0;
      commit  <= 1'b0;
      frame_o <= '0;
      overrun <= 1'b0;
    end else begin
      commit <= 1'b0;
      if (sync_fall) begin
        cnt     <= '0;
        overrun <= 1'b0;
      end else if (!sync_lvl && sclk_fall) begin
        shreg <= {shreg[FRAME_W-2:0], sdi_lvl};
        if (cnt <= FULL) cnt <= cnt + 1'b1;
        if (cnt == FULL) overrun <= 1'b1;
      end
      if (sync_rise && cnt == FULL) begin
        commit  <= 1'b1;
        frame_o <= frame_t'(shreg);
      end
    end
  end

  // R3
  commit_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(sync_rise));
  // R2
  short_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_rise && cnt < FULL) |=> !commit);
  // R4
  overrun_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !sync_fall) |=> overrun);
  // R4
  overrun_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && sync_rise) |=> !commit);
endmodule

// File: rtl/spi_rs_bank.sv
module spi_rs_bank
  import spi_rs_pkg::*;
#(
  parameter int NUM_CH = 40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               commit,
  input  frame_t             frame_i,
  output logic               rb_arm,
  output logic [FRAME_W-1:0] rb_word
);
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [DATA_W-1:0] in_a [NUM_CH];
  logic [DATA_W-1:0] in_b [NUM_CH];
  logic [DATA_W-1:0] ofs  [NUM_CH];
  logic [DATA_W-1:0] gain [NUM_CH];
  logic              bank_sel;

  logic              wr_ok;
  logic [CH_W-1:0]   wr_ch;
  logic              rd_ok;
  logic [CH_W-1:0]   rd_ch;
  rkind_e            rd_kind;
  logic [DATA_W-1:0] rd_val;

  assign wr_ok   = int'(frame_i.addr) < NUM_CH;
  assign wr_ch   = frame_i.addr[CH_W-1:0];
  assign rd_ok   = int'(frame_i.data[5:0]) < NUM_CH;
  assign rd_ch   = frame_i.data[CH_W-1:0];
  assign rd_kind = rkind_e'(frame_i.data[7:6]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_sel <= 1'b0;
      for (int i = 0; i < NUM_CH; i++) begin
        in_a[i] <= RST_IN;
        in_b[i] <= RST_IN;
        ofs[i]  <= RST_OFS;
        gain[i] <= RST_GAIN;
      end
    end else if (commit) begin
      unique case (frame_i.mode)
        MD_INPUT: if (wr_ok) begin
          if (bank_sel) in_b[wr_ch] <= frame_i.data;
          else          in_a[wr_ch] <= frame_i.data;
        end
        MD_OFFSET:  if (wr_ok) ofs[wr_ch]  <= frame_i.data;
        MD_GAIN:    if (wr_ok) gain[wr_ch] <= frame_i.data;
        MD_SPECIAL: if (is_banksel(frame_i)) bank_sel <= frame_i.data[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_val = '0;
    if (rd_ok) begin
      unique case (rd_kind)
        RK_IN_A: rd_val = in_a[rd_ch];
        RK_IN_B: rd_val = in_b[rd_ch];
        RK_OFS:  rd_val = ofs[rd_ch];
        RK_GAIN: rd_val = gain[rd_ch];
        default: rd_val = '0;
      endcase
    end
  end

  assign rb_arm  = commit && is_readcmd(frame_i);
  assign rb_word = pack_rb(rd_val);

  // R6
  banksel_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(bank_sel));
endmodule

// File: rtl/spi_rs_rb_tx.sv
module spi_rs_rb_tx
  import spi_rs_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               arm,
  input  logic [FRAME_W-1:0] word,
  input  logic               frame_start,
  input  logic               sync_rise,
  input  logic               sclk_rise,
  input  logic               sclk_fall,
  output logic               sdo,
  output logic               sdo_oe
);
  localparam int               CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] sh;
  logic [CNT_W-1:0]   cnt;
  logic               serving;
  logic               oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= '0;
      cnt     <= '0;
      serving <= 1'b0;
      oe      <= 1'b0;
    end else if (arm) begin
      oe      <= 1'b1;
      serving <= 1'b0;
      sh      <= word;
      cnt     <= '0;
    end else if (frame_start && oe) begin
      serving <= 1'b1;
      cnt     <= '0;
    end else if (serving) begin
      if (sync_rise) begin
        oe      <= 1'b0;
        serving <= 1'b0;
      end else if (sclk_fall) begin
        if (cnt == LAST) begin
          oe      <= 1'b0;
          serving <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (sclk_rise && cnt != '0) begin
        sh <= {sh[FRAME_W-2:0], 1'b0};
      end
    end
  end

  assign sdo_oe = oe;
  assign sdo    = oe & sh[FRAME_W-1];

  // R7
  oe_from_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe) |-> $past(arm));
  // R8
  oe_drop_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (serving && sclk_fall && !sync_rise && !arm && cnt == LAST) |=> !oe);
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_rs_pkg::*;
#(
  parameter int NUM_CH      = 40,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_n,
  input  logic sclk,
  input  logic sdi,
  output logic sdo,
  output logic sdo_oe,
  output logic overrun
);
  logic [2:0]         p_lvl, p_rise, p_fall;
  logic               commit;
  frame_t             frame;
  logic               rb_arm;
  logic [FRAME_W-1:0] rb_word;

  // bit 2 = frame line, bit 1 = serial clock, bit 0 = data
  spi_rs_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({sync_n, sclk, sdi}),
    .lvl(p_lvl), .rise(p_rise), .fall(p_fall)
  );

  spi_rs_frame_rx u_rx (
    .clk(clk), .rst_n(rst_n),
    .sync_lvl(p_lvl[2]), .sync_fall(p_fall[2]), .sync_rise(p_rise[2]),
    .sclk_fall(p_fall[1]), .sdi_lvl(p_lvl[0]),
    .commit(commit), .frame_o(frame), .overrun(overrun)
  );

  spi_rs_bank #(.NUM_CH(NUM_CH)) u_bank (
    .clk(clk), .rst_n(rst_n), .commit(commit), .frame_i(frame),
    .rb_arm(rb_arm), .rb_word(rb_word)
  );

  spi_rs_rb_tx u_tx (
    .clk(clk), .rst_n(rst_n), .arm(rb_arm), .word(rb_word),
    .frame_start(p_fall[2]), .sync_rise(p_rise[2]),
    .sclk_rise(p_rise[1]), .sclk_fall(p_fall[1]),
    .sdo(sdo), .sdo_oe(sdo_oe)
  );
endmodule

// File: tb/test_spi_reg_slave.sv
module test_spi_reg_slave;
  localparam int NCH = 40;
  localparam int HP  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_n = 1'b1;
  logic sclk = 1'b1;
  logic sdi = 1'b0;
  logic sdo, sdo_oe, overrun;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [15:0] m_a [NCH];
  logic [15:0] m_b [NCH];
  logic [15:0] m_o [NCH];
  logic [15:0] m_g [NCH];
  bit          m_sel;
  bit          m_pend;
  logic [23:0] m_rbw;

  spi_reg_slave #(.NUM_CH(NCH)) i_spi_reg_slave (
    .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .overrun(overrun)
  );

  always #10 clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] m_read(input logic [1:0] k, input int ch);
    if (ch >= NCH) return 16'h0;
    case (k)
      2'b00: return m_a[ch];
      2'b01: return m_b[ch];
      2'b10: return m_o[ch];
      default: return m_g[ch];
    endcase
  endfunction

  task automatic m_apply(input logic [23:0] w);
    int ch = int'(w[21:16]);
    case (w[23:22])
      2'b11: if (ch < NCH) begin if (m_sel) m_b[ch] = w[15:0]; else m_a[ch] = w[15:0]; end
      2'b10: if (ch < NCH) m_o[ch] = w[15:0];
      2'b01: if (ch < NCH) m_g[ch] = w[15:0];
      default: begin
        if (w[21:16] == 6'h01) m_sel = w[0];
        if (w[21:16] == 6'h05) begin
          m_pend = 1'b1;
          m_rbw  = {8'h00, m_read(w[7:6], int'(w[5:0]))};
        end
      end
    endcase
  endtask

  task automatic frame(input logic [23:0] w, input int nbits);
    bit          served = m_pend;
    logic [23:0] sw = m_rbw;
    m_pend = 1'b0;
    sync_n = 1'b0;
    tick(HP);
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 24) ? w[23-i] : 1'b1;
      tick(HP);
      if (served && i < 24) begin
        chk("R8 oe during served bit", 32'(sdo_oe), 32'd1);
        chk("R8 sdo bit", 32'(sdo), 32'(sw[23-i]));
      end
      sclk = 1'b0;
      tick(HP);
      if (i == 24) chk("R4 overrun on 25th edge", 32'(overrun), 32'd1);
      if (served && i == 23) chk("R8 oe off after 24th edge", 32'(sdo_oe), 32'd0);
      sclk = 1'b1;
    end
    tick(HP);
    sync_n = 1'b1;
    tick(2 * HP);
    if (nbits == 24) m_apply(w);
    chk("R2 R3 R7 oe after frame", 32'(sdo_oe), 32'(m_pend));
    chk("R4 overrun after frame", 32'(overrun), 32'(nbits > 24));
    if (!sdo_oe) chk("R9 sdo quiet", 32'(sdo), 32'd0);
    tick(HP);
  endtask

  function automatic logic [23:0] wr(input logic [1:0] md, input int ch, input logic [15:0] d);
    return {md, 6'(ch), d};
  endfunction

  task automatic rd(input logic [1:0] k, input int ch);
    frame({2'b00, 6'h05, 8'h00, k, 6'(ch)}, 24);
  endtask

  task automatic nop();
    frame(24'h000000, 24);
  endtask

  initial begin
    for (int i = 0; i < NCH; i++) begin
      m_a[i] = 16'h0; m_b[i] = 16'h0; m_o[i] = 16'h8000; m_g[i] = 16'hFFFF;
    end
    m_sel = 1'b0; m_pend = 1'b0; m_rbw = '0;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    // R9 reset state
    chk("R9 sdo_oe reset", 32'(sdo_oe), 32'd0);
    chk("R9 sdo reset", 32'(sdo), 32'd0);
    chk("R9 overrun reset", 32'(overrun), 32'd0);
    // R9 reset values via readback, R1 bit order
    rd(2'b00, 0); rd(2'b10, 3); rd(2'b11, 39); nop();
    // R5 input write with bank select 0
    frame(wr(2'b11, 5, 16'h1234), 24); rd(2'b00, 5); nop();
    // R6 bank select to 1, R5 routing
    frame({2'b00, 6'h01, 16'h0001}, 24);
    frame(wr(2'b11, 5, 16'hABCD), 24); rd(2'b01, 5); rd(2'b00, 5); nop();
    // R5 offset and gain
    frame(wr(2'b10, 39, 16'h4321), 24); frame(wr(2'b01, 0, 16'h00FF), 24);
    rd(2'b10, 39); rd(2'b11, 0); nop();
    // R2 short frame
    frame(wr(2'b01, 0, 16'h0000), 20); rd(2'b11, 0); nop();
    // R4 overlong frame
    frame(wr(2'b01, 0, 16'h0000), 26); rd(2'b11, 0); nop();
    // R5 R7 out-of-range channel
    frame(wr(2'b11, 45, 16'h5555), 24); rd(2'b01, 45); nop();
    // R6 unknown special address leaves bank select alone
    frame({2'b00, 6'h10, 16'h0000}, 24);
    frame(wr(2'b11, 2, 16'h7777), 24); rd(2'b01, 2); rd(2'b00, 2); nop();
    // R8 served frame cut short
    rd(2'b11, 39); frame(24'h000000, 10); nop();
    // R6 bank select back to 0
    frame({2'b00, 6'h01, 16'h0000}, 24);
    frame(wr(2'b11, 6, 16'h0F0F), 24); rd(2'b00, 6); rd(2'b01, 6); nop();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule